// File: doc/BRIEF.md
# Binarized Neuron Layer with XNOR Agreement Counting

This block evaluates one layer of a binarized neural network without any multiplier. Every activation and weight is one bit, where a 1 stands for +1 and a 0 stands for −1. Each clock cycle the block can accept one N-bit activation vector. Every neuron in the layer sees that same vector. For each neuron the block compares the vector with the neuron's weight vector bit by bit, which is the XNOR of the two bits and equals their ±1 product. It then counts the agreeing positions in a registered adder tree and checks the count against a per-neuron threshold.

Weights and thresholds sit in registers that a single-cycle write port loads, one neuron per write. Each result carries two values per neuron. The first is a binary activation, which is the sign decision. The second is the signed dot product 2·P − N, where P is the agreement count. A valid strobe travels with every vector through a fixed-length pipeline.

Top module: `bnn_xnor_layer`

## Requirements
- R1: A bit value of 1 encodes +1 and 0 encodes −1 for both activations and weights. The per-position product is the XNOR of the two bits. The agreement count P of neuron k is the number of positions where the input bit equals bit position i of that neuron's weight vector.
- R2: When out_valid_o is 1, field k of out_dot_o, bits [k*DOT_W +: DOT_W], holds the two's-complement value 2·P − N for neuron k. Here DOT_W = ceil(log2(N+1)) + 1.
- R3: When out_valid_o is 1, out_act_o[k] is 1 exactly when P of neuron k is greater than or equal to that neuron's threshold. A threshold of 0 always gives 1, and a threshold of N+1 never does.
- R4: A new vector is accepted on every cycle in which in_valid_i is 1, without any stall. A burst of back-to-back vectors produces the same number of back-to-back results.
- R5: out_valid_o is 1 exactly ceil(log2 N) + 1 cycles after a cycle in which in_valid_i was sampled as 1, and 0 otherwise.
- R6: A cycle with wr_en_i at 1 loads wr_weight_i and wr_thresh_i into neuron wr_sel_i. Weights and thresholds of the other neurons stay unchanged, and nothing changes while wr_en_i is 0.
- R7: A vector accepted in the same cycle as a write still uses the old weight and threshold of that neuron. Vectors already in the pipeline finish with the threshold they were launched with.
- R8: Driving rst_ni low clears out_valid_o, out_act_o and every valid flag in the pipeline at once. It also sets every weight bit to 0 and every threshold to 0, so the first vector after reset fires all neurons and reports 2·(number of zero input bits) − N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Activation vector present this cycle |
| in_act_i | input | N | Input activation bits |
| wr_en_i | input | 1 | Load one neuron's weight and threshold |
| wr_sel_i | input | max(1, ceil(log2 M)) | Neuron index for the write |
| wr_weight_i | input | N | Weight bits to load |
| wr_thresh_i | input | ceil(log2(N+1)) | Agreement threshold to load |
| out_valid_o | output | 1 | Result valid |
| out_act_o | output | M | One binary activation per neuron |
| out_dot_o | output | M*DOT_W | Signed dot product per neuron, packed with neuron 0 in the lowest field |

## Verification
On every cycle, assertions check three things. The first is that out_valid_o follows in_valid_i at exactly the pipeline latency. The second is that every reported dot product lies within ±N and has the parity of N. The third is that a write lands in the selected neuron while idle cycles leave the weight bank untouched. The bench's scenarios are needed for the rest: exact agreement counts, the threshold edge values 0, N and N+1, write-versus-launch ordering, and the weight and threshold state that reset leaves behind. These depend on the data, and only an independent model compared at the output can show them.

// File: rtl/bnn_pkg.sv
package bnn_pkg;
  function automatic int cnt_width(input int n);
    return $clog2(n + 1);
  endfunction

  function automatic int tree_depth(input int n);
    return $clog2(n);
  endfunction

  function automatic int sel_width(input int m);
    return (m > 1) ? $clog2(m) : 1;
  endfunction
endpackage

// File: rtl/bnn_weight_bank.sv
module bnn_weight_bank #(
  parameter int N     = 64,
  parameter int M     = 4,
  parameter int CNT_W = 7,
  parameter int SEL_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [SEL_W-1:0]   wr_sel_i,
  input  logic [N-1:0]       wr_weight_i,
  input  logic [CNT_W-1:0]   wr_thresh_i,
  output logic [M*N-1:0]     weights_o,
  output logic [M*CNT_W-1:0] thresh_o
);
  logic [N-1:0]     w_q [M];
  logic [CNT_W-1:0] t_q [M];

  for (genvar k = 0; k < M; k++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        w_q[k] <= '0;
        t_q[k] <= '0;
      end else if (wr_en_i && (wr_sel_i == SEL_W'(k))) begin
        w_q[k] <= wr_weight_i;
        t_q[k] <= wr_thresh_i;
      end
    end
    assign weights_o[k*N +: N]         = w_q[k];
    assign thresh_o[k*CNT_W +: CNT_W]  = t_q[k];
  end

  p_wr_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (int'(wr_sel_i) < M)) |=>
      (weights_o[int'($past(wr_sel_i))*N +: N] == $past(wr_weight_i)) &&
      (thresh_o[int'($past(wr_sel_i))*CNT_W +: CNT_W] == $past(wr_thresh_i)))
    else $error("write did not land in selected neuron");

  p_idle_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(weights_o) && $stable(thresh_o)))
    else $error("weight bank changed without a write");
endmodule

// File: rtl/bnn_popcount_tree.sv
module bnn_popcount_tree #(
  parameter int N     = 64,
  parameter int CNT_W = 7,
  parameter int DEPTH = 6
) (
  input  logic             clk_i,
  input  logic [N-1:0]     bits_i,
  output logic [CNT_W-1:0] count_o
);
  localparam int PAD   = 1 << DEPTH;
  localparam int NODES = PAD - 1;

  logic [PAD-1:0]   leaf;
  logic [CNT_W-1:0] node_q [NODES];
  logic [CNT_W-1:0] kid    [2*PAD-1];

  assign leaf = PAD'(bits_i);

  for (genvar j = 0; j < PAD; j++) begin : g_leaf
    assign kid[NODES+j] = CNT_W'(leaf[j]);
  end

  // heap layout: node i sums kids 2i+1 and 2i+2, one register per level
  for (genvar i = 0; i < NODES; i++) begin : g_node
    assign kid[i] = node_q[i];
    always_ff @(posedge clk_i) begin
      node_q[i] <= kid[2*i+1] + kid[2*i+2];
    end
  end

  assign count_o = node_q[0];
endmodule

// File: rtl/bnn_pipe_delay.sv
module bnn_pipe_delay #(
  parameter int W   = 1,
  parameter int D   = 6,
  parameter bit RST = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [D];

  for (genvar s = 0; s < D; s++) begin : g_stage
    logic [W-1:0] src;
    if (s == 0) begin : g_head
      assign src = d_i;
    end else begin : g_body
      assign src = stage_q[s-1];
    end
    if (RST) begin : g_rst
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= src;
      end
    end else begin : g_norst
      always_ff @(posedge clk_i) begin
        stage_q[s] <= src;
      end
    end
  end

  assign q_o = stage_q[D-1];
endmodule

// File: rtl/bnn_xnor_layer.sv
module bnn_xnor_layer #(
  parameter int N = 64,
  parameter int M = 4
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   in_valid_i,
  input  logic [N-1:0]                           in_act_i,
  input  logic                                   wr_en_i,
  input  logic [bnn_pkg::sel_width(M)-1:0]       wr_sel_i,
  input  logic [N-1:0]                           wr_weight_i,
  input  logic [bnn_pkg::cnt_width(N)-1:0]       wr_thresh_i,
  output logic                                   out_valid_o,
  output logic [M-1:0]                           out_act_o,
  output logic [M*(bnn_pkg::cnt_width(N)+1)-1:0] out_dot_o
);
  localparam int CNT_W = bnn_pkg::cnt_width(N);
  localparam int DEPTH = bnn_pkg::tree_depth(N);
  localparam int SEL_W = bnn_pkg::sel_width(M);
  localparam int DOT_W = CNT_W + 1;
  localparam int LAT   = DEPTH + 1;
  localparam int SIN_W = $clog2(LAT + 1);

  logic [M*N-1:0]     weights;
  logic [M*CNT_W-1:0] thresh;
  logic [M*CNT_W-1:0] thresh_d;
  logic               valid_d;
  logic [CNT_W-1:0]   cnt [M];

  bnn_weight_bank #(.N(N), .M(M), .CNT_W(CNT_W), .SEL_W(SEL_W)) i_bank (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_weight_i, .wr_thresh_i,
    .weights_o(weights), .thresh_o(thresh)
  );

  bnn_pipe_delay #(.W(1), .D(DEPTH), .RST(1'b1)) i_valid_dly (
    .clk_i, .rst_ni, .d_i(in_valid_i), .q_o(valid_d)
  );

  // thresholds travel with the vector so later writes cannot reach it
  bnn_pipe_delay #(.W(M*CNT_W), .D(DEPTH), .RST(1'b0)) i_thr_dly (
    .clk_i, .rst_ni, .d_i(thresh), .q_o(thresh_d)
  );

  for (genvar k = 0; k < M; k++) begin : g_neuron
    logic [N-1:0] agree;
    assign agree = ~(in_act_i ^ weights[k*N +: N]);

    bnn_popcount_tree #(.N(N), .CNT_W(CNT_W), .DEPTH(DEPTH)) i_tree (
      .clk_i, .bits_i(agree), .count_o(cnt[k])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        out_act_o[k]               <= 1'b0;
        out_dot_o[k*DOT_W +: DOT_W] <= '0;
      end else if (valid_d) begin
        out_act_o[k]               <= (cnt[k] >= thresh_d[k*CNT_W +: CNT_W]);
        out_dot_o[k*DOT_W +: DOT_W] <= DOT_W'({cnt[k], 1'b0}) - DOT_W'(N);
      end
    end

    p_dot_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o |-> (($signed(out_dot_o[k*DOT_W +: DOT_W]) <= N) &&
                       ($signed(out_dot_o[k*DOT_W +: DOT_W]) >= -N) &&
                       (out_dot_o[k*DOT_W] == N[0])))
      else $error("dot product out of range or wrong parity");
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_valid_o <= 1'b0;
    else         out_valid_o <= valid_d;
  end

  logic [SIN_W-1:0] since_rst_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       since_rst_q <= '0;
    else if (since_rst_q != SIN_W'(LAT)) since_rst_q <= since_rst_q + 1'b1;
  end

  p_latency_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst_q == SIN_W'(LAT)) |-> (out_valid_o == $past(in_valid_i, LAT)))
    else $error("valid latency mismatch");
endmodule

// File: tb/test_bnn_xnor_layer.sv
module test_bnn_xnor_layer;
  localparam int CLK_PERIOD = 10;
  localparam int N     = 64;
  localparam int M     = 4;
  localparam int CNT_W = 7;
  localparam int DOT_W = CNT_W + 1;
  localparam int SEL_W = 2;
  localparam int LAT   = 7;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic in_valid_i = 1'b0;
  logic [N-1:0] in_act_i = '0;
  logic wr_en_i = 1'b0;
  logic [SEL_W-1:0] wr_sel_i = '0;
  logic [N-1:0] wr_weight_i = '0;
  logic [CNT_W-1:0] wr_thresh_i = '0;
  logic out_valid_o;
  logic [M-1:0] out_act_o;
  logic [M*DOT_W-1:0] out_dot_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bnn_xnor_layer #(.N(N), .M(M)) i_bnn_xnor_layer (.*);

  int checks = 0;
  int errors = 0;
  int vcount = 0;
  bit done = 0;

  logic [N-1:0] mw [M];
  int           mt [M];
  bit           pv   [LAT];
  logic [M-1:0] pact [LAT];
  int           pdot [LAT][M];
  string        ptag [LAT];

  function automatic int agree_cnt(input logic [N-1:0] x, input logic [N-1:0] w);
    return $countones(~(x ^ w));
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int k = 0; k < M; k++) begin mw[k] = '0; mt[k] = 0; end
    for (int s = 0; s < LAT; s++) begin pv[s] = 0; pact[s] = '0; ptag[s] = ""; end
  endtask

  task automatic step(input bit v, input logic [N-1:0] x, input bit we, input int sel,
                      input logic [N-1:0] ww, input int wt, input string tag);
    @(negedge clk_i);
    if (pv[LAT-1]) begin
      check(out_valid_o === 1'b1, "R5", "out_valid", out_valid_o, 1);
      check(out_act_o === pact[LAT-1], (ptag[LAT-1] == "") ? "R3" : ptag[LAT-1],
            "out_act", out_act_o, pact[LAT-1]);
      for (int k = 0; k < M; k++)
        check($signed(out_dot_o[k*DOT_W +: DOT_W]) == pdot[LAT-1][k],
              (ptag[LAT-1] == "") ? "R2" : ptag[LAT-1], "out_dot",
              $signed(out_dot_o[k*DOT_W +: DOT_W]), pdot[LAT-1][k]);
    end else begin
      check(out_valid_o === 1'b0, "R5", "out_valid idle", out_valid_o, 0);
    end
    if (out_valid_o === 1'b1) vcount++;
    for (int s = LAT-1; s > 0; s--) begin
      pv[s] = pv[s-1]; pact[s] = pact[s-1]; ptag[s] = ptag[s-1];
      for (int k = 0; k < M; k++) pdot[s][k] = pdot[s-1][k];
    end
    pv[0] = v; ptag[0] = tag;
    for (int k = 0; k < M; k++) begin
      int p;
      p = agree_cnt(x, mw[k]);
      pdot[0][k] = 2*p - N;
      pact[0][k] = (p >= mt[k]);
    end
    in_valid_i  = v;
    in_act_i    = x;
    wr_en_i     = we;
    wr_sel_i    = sel[SEL_W-1:0];
    wr_weight_i = ww;
    wr_thresh_i = wt[CNT_W-1:0];
    if (we) begin mw[sel] = ww; mt[sel] = wt; end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, '0, 0, 0, '0, 0, "");
  endtask

  task automatic wr(input int sel, input logic [N-1:0] ww, input int wt);
    step(0, '0, 1, sel, ww, wt, "R6");
  endtask

  function automatic logic [N-1:0] rnd_vec();
    return {$urandom, $urandom};
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    model_clear();
    repeat (3) @(negedge clk_i);
    // R8: outputs cleared under reset
    check(out_valid_o === 1'b0, "R8", "out_valid in reset", out_valid_o, 0);
    check(out_act_o === '0, "R8", "out_act in reset", out_act_o, 0);
    rst_ni = 1'b1;

    // R8: zero weights, zero thresholds after reset
    step(1, {N{1'b1}}, 0, 0, '0, 0, "R8");
    step(1, 64'h0000_0000_FFFF_0000, 0, 0, '0, 0, "R8");
    idle(LAT);

    // R3 threshold edges: N+1 never, N on full agreement, one miss below N
    wr(0, {N{1'b1}}, N+1);
    wr(1, {N{1'b1}}, N);
    wr(2, {N{1'b1}}, N);
    wr(3, 64'h0F0F_0F0F_0F0F_0F0F, 0);
    step(1, {N{1'b1}}, 0, 0, '0, 0, "R3");
    step(1, ~(64'd1 << 5), 0, 0, '0, 0, "R3");
    step(1, '0, 0, 0, '0, 0, "R3");
    idle(LAT);

    // R1: mixed patterns against known weights
    wr(1, 64'hAAAA_AAAA_5555_5555, 32);
    step(1, 64'hAAAA_AAAA_AAAA_AAAA, 0, 0, '0, 0, "R1");
    step(1, 64'h5555_5555_5555_5555, 0, 0, '0, 0, "R1");
    step(1, 64'h8000_0000_0000_0001, 0, 0, '0, 0, "R1");
    idle(LAT);

    // R7: write in the same cycle as a launch, then rewrite while in flight
    step(1, {N{1'b1}}, 1, 1, '0, 0, "R7");
    step(1, {N{1'b1}}, 1, 0, {N{1'b1}}, 0, "R7");
    step(1, {N{1'b1}}, 1, 2, '0, N+1, "R7");
    step(1, {N{1'b1}}, 0, 0, '0, 0, "R7");
    idle(LAT);

    // R4: back-to-back burst
    vcount = 0;
    for (int i = 0; i < 20; i++) step(1, rnd_vec(), 0, 0, '0, 0, "R4");
    idle(LAT);
    check(vcount == 20, "R4", "burst result count", vcount, 20);

    // random traffic with interleaved writes
    for (int i = 0; i < 2000; i++) begin
      bit v, we;
      int wt;
      v  = ($urandom % 4) != 0;
      we = ($urandom % 8) == 0;
      wt = (($urandom % 2) == 0) ? int'($urandom % (N+2)) : (N/2 - 6 + int'($urandom % 13));
      step(v, rnd_vec(), we, int'($urandom % M), rnd_vec(), wt, "");
    end

    // R8: reset with a full pipeline
    for (int i = 0; i < 4; i++) step(1, rnd_vec(), 1, i, rnd_vec(), 40, "");
    @(negedge clk_i);
    rst_ni = 1'b0;
    in_valid_i = 1'b0;
    wr_en_i = 1'b0;
    #1;
    check(out_valid_o === 1'b0, "R8", "out_valid at reset", out_valid_o, 0);
    check(out_act_o === '0, "R8", "out_act at reset", out_act_o, 0);
    model_clear();
    @(negedge clk_i);
    rst_ni = 1'b1;
    idle(LAT);
    step(1, 64'h0123_4567_89AB_CDEF, 0, 0, '0, 0, "R8");
    step(1, rnd_vec(), 0, 0, '0, 0, "R8");
    idle(LAT + 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule